// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Time Threshold Programming

This block is a one-way first-in first-out buffer between two unrelated clocks. Words of 36 bits are written on clock A and read on clock B, with room for 512 of them. The write side shows input-ready and an almost-full flag. The read side shows output-ready, the oldest stored word, and an almost-empty flag.

The two flag thresholds are fixed while the block comes out of reset. A two-bit mode select is sampled on the first clock-A edge after reset is released. Any value other than zero loads both thresholds with a preset of eight, and normal writes begin at once. A value of zero puts the write side into a programming phase. In that phase the next two accepted words on the write bus set the thresholds and are not stored. Only after both have been taken does the buffer start to fill.

Read and write pointers cross between the clocks as Gray codes through two-flop synchronizers. Each flag is computed in the domain where it is output.

Top module: `fifo_loader`

## Requirements
- R1: While reset is high, input-ready and almost-full are 0, output-ready is 0 and almost-empty is 1.
- R2: If the mode select is not 0 (for example binary 01) on the first clock-A edge after reset release, both thresholds become 8 and input-ready rises within a few clock-A cycles with no programming words needed.
- R3: If the mode select is 0 at release, the first accepted write sets the almost-full threshold from data bits [8:0], and the second sets the almost-empty threshold from data bits [8:0]. Idle cycles between them are allowed. Neither word is stored, and the first word stored is the third accepted write.
- R4: A write is accepted only on a rising clock-A edge with chip-select low, write/read select high, mailbox select low, write enable high and input-ready high. Any other combination changes nothing.
- R5: Almost-empty is 1 when the word count seen by the read side is less than or equal to the almost-empty threshold.
- R6: Almost-full is 1 when the free space seen by the write side is less than or equal to the almost-full threshold.
- R7: Input-ready is 0 while 512 words are stored, and writes presented then are ignored.
- R8: Output-ready is 1 exactly when at least one stored word is visible to the read side. The read-data output then shows the oldest word, and read enable together with output-ready consumes it on a rising clock-B edge.
- R9: Words leave in the order they were accepted, with none lost or repeated, while both sides run at the same time.
- R10: After reset, output-ready stays 0 until the first stored data word reaches the read side. Threshold words never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Write-side clock |
| clkB | input | 1 | Read-side clock |
| rst | input | 1 | Asynchronous reset, active high, released synchronously per domain |
| modeSel | input | 2 | Threshold mode, sampled at reset release (0 = program from bus) |
| csN | input | 1 | Chip select, active low |
| wrSel | input | 1 | Write/read select, high for write |
| mbSel | input | 1 | Mailbox select, must be low for a write |
| wrEn | input | 1 | Write enable |
| wrData | input | 36 | Write data or threshold word |
| inputRdy | output | 1 | Write side can accept a word |
| almostFull | output | 1 | Free space at or below the almost-full threshold |
| rdEn | input | 1 | Read enable |
| rdData | output | 36 | Oldest stored word |
| outputRdy | output | 1 | A word is available at rdData |
| almostEmpty | output | 1 | Word count at or below the almost-empty threshold |

## Verification
The bench uses the default parameters: 36-bit words, depth 512 and preset 8. A full buffer and both edges of each preset threshold are therefore reachable within a few thousand cycles. Clock B runs at a period unrelated to clock A, so the Gray-code crossings see shifting edge phases. A programmed run with thresholds of 20 and 5, and a run with random thresholds, exercise the bus-loaded thresholds.

// File: rtl/fifo_loader_pkg.sv
`timescale 1ns/1ps
package fifo_loader_pkg;

  // Strobes from the write-side control to the datapath; at most one per cycle.
  typedef struct packed {
    logic presetLoad;
    logic loadAf;
    logic loadAe;
    logic wrWord;
  } loaderStrb_t;

  typedef enum logic [1:0] {
    ST_RESET,
    ST_PROG_AF,
    ST_PROG_AE,
    ST_RUN
  } loaderState_t;

  localparam logic [1:0] SEL_PROGRAM = 2'b00;

endpackage

// File: rtl/fifo_loader_sync.sv
`timescale 1ns/1ps
module fifo_loader_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/fifo_loader_ctrl.sv
`timescale 1ns/1ps
module fifo_loader_ctrl
  import fifo_loader_pkg::*;
(
  input  logic        clkA,
  input  logic        rstA,
  input  logic [1:0]  modeSel,
  input  logic        csN,
  input  logic        wrSel,
  input  logic        mbSel,
  input  logic        wrEn,
  input  logic        full,
  output logic        inputRdy,
  output loaderStrb_t strb
);

  loaderState_t state, stateNext;
  logic wrQual;

  assign inputRdy = (state != ST_RESET) && !full;
  assign wrQual   = !csN && wrSel && !mbSel && wrEn && inputRdy;

  always_comb begin
    strb            = '0;
    stateNext       = state;
    unique case (state)
      ST_RESET: begin
        if (modeSel == SEL_PROGRAM) begin
          stateNext = ST_PROG_AF;
        end else begin
          strb.presetLoad = 1'b1;
          stateNext       = ST_RUN;
        end
      end
      ST_PROG_AF: if (wrQual) begin
        strb.loadAf = 1'b1;
        stateNext   = ST_PROG_AE;
      end
      ST_PROG_AE: if (wrQual) begin
        strb.loadAe = 1'b1;
        stateNext   = ST_RUN;
      end
      ST_RUN: strb.wrWord = wrQual;
      default: stateNext = ST_RESET;
    endcase
  end

  always_ff @(posedge clkA or posedge rstA) begin
    if (rstA) state <= ST_RESET;
    else      state <= stateNext;
  end

endmodule

// File: rtl/fifo_loader_datapath.sv
`timescale 1ns/1ps
module fifo_loader_datapath
  import fifo_loader_pkg::*;
#(
  parameter int DATA_W     = 36,
  parameter int ADDR_W     = 9,
  parameter int PRESET_OFF = 8
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstA,
  input  logic              rstB,
  input  loaderStrb_t       strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic              full,
  output logic              almostFull,
  output logic [DATA_W-1:0] rdData,
  output logic              outputRdy,
  output logic              almostEmpty
);

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] PRESET_V = ADDR_W'(PRESET_OFF);

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wPtr, wGray, rPtr, rGray;
  logic [PTR_W-1:0]  rGraySyncA, wGraySyncB;
  logic [PTR_W-1:0]  wrCount, freeCnt, rdCount;
  logic [ADDR_W-1:0] afOff, aeOff;
  logic              rdAccept;

  // ---------------- write domain ----------------
  always_ff @(posedge clkA) begin
    if (strb.wrWord) mem[wPtr[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clkA or posedge rstA) begin
    if (rstA) begin
      wPtr  <= '0;
      wGray <= '0;
      afOff <= '0;
      aeOff <= '0;
    end else begin
      if (strb.wrWord) begin
        wPtr  <= wPtr + 1'b1;
        wGray <= bin2gray(wPtr + 1'b1);
      end
      if (strb.presetLoad) begin
        afOff <= PRESET_V;
        aeOff <= PRESET_V;
      end
      if (strb.loadAf) afOff <= wrData[ADDR_W-1:0];
      if (strb.loadAe) aeOff <= wrData[ADDR_W-1:0];
    end
  end

  fifo_loader_sync #(.WIDTH(PTR_W), .STAGES(2), .RST_VAL('0)) i_rdPtrToA (
    .clk(clkA), .arst(rstA), .d(rGray), .q(rGraySyncA)
  );

  assign wrCount    = wPtr - gray2bin(rGraySyncA);
  assign freeCnt    = DEPTH_V - wrCount;
  assign full       = wrCount[ADDR_W];
  assign almostFull = freeCnt <= {1'b0, afOff};

  // ---------------- read domain ----------------
  fifo_loader_sync #(.WIDTH(PTR_W), .STAGES(2), .RST_VAL('0)) i_wrPtrToB (
    .clk(clkB), .arst(rstB), .d(wGray), .q(wGraySyncB)
  );

  assign rdCount     = gray2bin(wGraySyncB) - rPtr;
  assign outputRdy   = rdCount != '0;
  // aeOff only changes while nothing is stored, so it is quasi-static here.
  assign almostEmpty = rdCount <= {1'b0, aeOff};
  assign rdAccept    = rdEn && outputRdy;
  assign rdData      = mem[rPtr[ADDR_W-1:0]];

  always_ff @(posedge clkB or posedge rstB) begin
    if (rstB) begin
      rPtr  <= '0;
      rGray <= '0;
    end else if (rdAccept) begin
      rPtr  <= rPtr + 1'b1;
      rGray <= bin2gray(rPtr + 1'b1);
    end
  end

endmodule

// File: rtl/fifo_loader.sv
`timescale 1ns/1ps
module fifo_loader
  import fifo_loader_pkg::*;
#(
  parameter int DATA_W     = 36,
  parameter int ADDR_W     = 9,
  parameter int PRESET_OFF = 8
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rst,
  input  logic [1:0]        modeSel,
  input  logic              csN,
  input  logic              wrSel,
  input  logic              mbSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              inputRdy,
  output logic              almostFull,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              outputRdy,
  output logic              almostEmpty
);

  logic        rstA, rstB, full;
  loaderStrb_t strb;

  fifo_loader_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b1)) i_rstA (
    .clk(clkA), .arst(rst), .d(1'b0), .q(rstA)
  );
  fifo_loader_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b1)) i_rstB (
    .clk(clkB), .arst(rst), .d(1'b0), .q(rstB)
  );

  fifo_loader_ctrl i_ctrl (
    .clkA(clkA), .rstA(rstA), .modeSel(modeSel), .csN(csN), .wrSel(wrSel),
    .mbSel(mbSel), .wrEn(wrEn), .full(full), .inputRdy(inputRdy), .strb(strb)
  );

  fifo_loader_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESET_OFF(PRESET_OFF)) i_dp (
    .clkA(clkA), .clkB(clkB), .rstA(rstA), .rstB(rstB), .strb(strb),
    .wrData(wrData), .rdEn(rdEn), .full(full), .almostFull(almostFull),
    .rdData(rdData), .outputRdy(outputRdy), .almostEmpty(almostEmpty)
  );

endmodule

// File: rtl/fifo_loader_chk.sv
`timescale 1ns/1ps
module fifo_loader_chk
  import fifo_loader_pkg::*;
(
  input logic        clkA,
  input logic        clkB,
  input logic        rst,
  input logic        inputRdy,
  input logic        almostFull,
  input logic        rdEn,
  input logic        outputRdy,
  input logic        almostEmpty,
  input loaderStrb_t strb
);

  // R1
  a_r1_write_side_quiet: assert property (@(posedge clkA)
    rst |-> (!inputRdy && !almostFull));

  // R1
  a_r1_read_side_quiet: assert property (@(posedge clkB)
    rst |-> (!outputRdy && almostEmpty));

  // R3: threshold loads, preset and stores never coincide
  a_r3_strobes_exclusive: assert property (@(posedge clkA) disable iff (rst)
    $onehot0(strb));

  // R5: nothing visible means at or below any threshold
  a_r5_empty_is_almost_empty: assert property (@(posedge clkB) disable iff (rst)
    !outputRdy |-> almostEmpty);

  // R5: the count can only fall through a read
  a_r5_ae_rises_on_read: assert property (@(posedge clkB) disable iff (rst)
    (!almostEmpty && !(rdEn && outputRdy)) |=> !almostEmpty);

  // R6: free space can only shrink through a stored write
  a_r6_af_rises_on_write: assert property (@(posedge clkA) disable iff (rst)
    (!almostFull && !strb.wrWord) |=> !almostFull);

  // R7: input-ready drops only when the buffer has filled
  a_r7_ready_drop_full: assert property (@(posedge clkA) disable iff (rst)
    $fell(inputRdy) |-> almostFull);

  // R8: a visible word stays visible until read
  a_r8_word_held: assert property (@(posedge clkB) disable iff (rst)
    (outputRdy && !rdEn) |=> outputRdy);

endmodule

bind fifo_loader fifo_loader_chk i_chk (
  .clkA(clkA), .clkB(clkB), .rst(rst), .inputRdy(inputRdy),
  .almostFull(almostFull), .rdEn(rdEn), .outputRdy(outputRdy),
  .almostEmpty(almostEmpty), .strb(strb)
);

// File: tb/test_fifo_loader.sv
`timescale 1ns/1ps
module test_fifo_loader;

  localparam int DEPTH = 512;

  logic        clkA = 1'b0, clkB = 1'b0, rst = 1'b1;
  logic [1:0]  modeSel = 2'b01;
  logic        csN = 1'b0, wrSel = 1'b1, mbSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [35:0] wrData = '0;
  logic        inputRdy, almostFull, outputRdy, almostEmpty;
  logic [35:0] rdData;

  always #5 clkA = ~clkA;
  always #6.5 clkB = ~clkB;

  fifo_loader i_fifo_loader (
    .clkA(clkA), .clkB(clkB), .rst(rst), .modeSel(modeSel), .csN(csN),
    .wrSel(wrSel), .mbSel(mbSel), .wrEn(wrEn), .wrData(wrData),
    .inputRdy(inputRdy), .almostFull(almostFull), .rdEn(rdEn),
    .rdData(rdData), .outputRdy(outputRdy), .almostEmpty(almostEmpty)
  );

  int          nChk = 0, nFail = 0;
  logic [35:0] q[$];
  int          afExp = 0, aeExp = 0, progLeft = 0;
  bit          wDone;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] rndWord();
    return {4'($urandom()), 32'($urandom())};
  endfunction

  // Expected flag values from the requirements.
  function automatic logic expAf(int n);  return (DEPTH - n) <= afExp; endfunction
  function automatic logic expAe(int n);  return n <= aeExp;           endfunction

  // bad: [0] chip select high, [1] read select, [2] mailbox select, [3] enable low
  task automatic wrA(input logic [35:0] d, input logic [3:0] bad);
    @(negedge clkA);
    wrData = d;
    csN    = bad[0];
    wrSel  = !bad[1];
    mbSel  = bad[2];
    wrEn   = !bad[3];
    if (bad == 4'd0 && inputRdy) begin
      if (progLeft == 2)      afExp = int'(d[8:0]);
      else if (progLeft == 1) aeExp = int'(d[8:0]);
      else                    q.push_back(d);
      if (progLeft > 0) progLeft--;
    end
  endtask

  task automatic wrIdle();
    @(negedge clkA);
    wrEn = 1'b0; csN = 1'b0; wrSel = 1'b1; mbSel = 1'b0;
  endtask

  task automatic fill(input int n);
    repeat (n) wrA(rndWord(), 4'd0);
    wrIdle();
  endtask

  task automatic settle();
    repeat (6) @(negedge clkB);
    repeat (6) @(negedge clkA);
  endtask

  task automatic checkSides(input string tag);
    @(negedge clkA);
    chk({tag, " R6 almostFull"}, almostFull, expAf(q.size()));
    chk({tag, " R7 inputRdy"}, inputRdy, q.size() < DEPTH);
    @(negedge clkB);
    chk({tag, " R5 almostEmpty"}, almostEmpty, expAe(q.size()));
    chk({tag, " R8 outputRdy"}, outputRdy, q.size() != 0);
    if (q.size() != 0) chk({tag, " R8 oldest word"}, rdData, q[0]);
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 4 * DEPTH) begin
      @(negedge clkB);
      if (outputRdy) begin
        chk("R9 drain order", rdData, q[0]);
        void'(q.pop_front());
        rdEn = 1'b1;
      end else rdEn = 1'b0;
      guard++;
    end
    @(negedge clkB);
    rdEn = 1'b0;
    chk("R9 drain complete", q.size(), 0);
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clkA);
    rst = 1'b1; modeSel = m; wrEn = 1'b0; rdEn = 1'b0;
    repeat (4) @(negedge clkA);
    chk("R1 inputRdy in reset", inputRdy, 0);
    chk("R1 almostFull in reset", almostFull, 0);
    @(negedge clkB);
    chk("R1 outputRdy in reset", outputRdy, 0);
    chk("R1 almostEmpty in reset", almostEmpty, 1);
    @(negedge clkA);
    rst = 1'b0;
    q.delete();
    progLeft = (m == 2'b00) ? 2 : 0;
    afExp    = (m == 2'b00) ? 0 : 8;
    aeExp    = (m == 2'b00) ? 0 : 8;
    repeat (6) @(negedge clkA);
    modeSel = ~m;  // sampled only at release
  endtask

  initial begin
    repeat (150000) @(posedge clkA);
    nFail++;
    $display("FAIL watchdog: actual run still active, expected completion");
    report();
  end

  initial begin
    int unused;
    unused = $urandom(32'd2024);

    // ---- preset mode (R2, R5, R6, R7, R8) ----
    doReset(2'b01);
    chk("R2 inputRdy after release", inputRdy, 1);
    fill(8);       settle(); checkSides("R2 count 8");
    fill(1);       settle(); checkSides("R2 count 9");
    fill(494);     settle(); checkSides("R6 count 503");
    fill(1);       settle(); checkSides("R6 count 504");
    fill(8);       settle(); checkSides("R7 count 512");
    wrA(rndWord(), 4'd0); wrIdle(); settle();  // presented while full
    checkSides("R7 write while full");
    chk("R7 model size", q.size(), DEPTH);
    drain();       settle(); checkSides("R9 after drain");

    // ---- programming mode (R3, R4, R10) ----
    doReset(2'b00);
    chk("R10 outputRdy before data", outputRdy, 0);
    wrA(rndWord(), 4'b0001);
    wrA(rndWord(), 4'b0010);
    wrA(rndWord(), 4'b0100);
    wrA(rndWord(), 4'b1000);
    wrA({27'h5a5a5a5, 9'd20}, 4'd0);
    wrIdle(); repeat (3) @(negedge clkA);      // gap between threshold words
    wrA({27'h1234567, 9'd5}, 4'd0);
    wrIdle(); settle();
    chk("R3 af threshold taken", afExp, 20);
    checkSides("R3 R10 threshold words not stored");
    wrA(rndWord(), 4'b0100); wrIdle(); settle();
    checkSides("R4 mailbox select blocks store");
    wrA(rndWord(), 4'b0001); wrIdle(); settle();
    checkSides("R4 chip select blocks store");
    fill(5);       settle(); checkSides("R3 R5 count 5");
    fill(1);       settle(); checkSides("R3 R5 count 6");
    fill(485);     settle(); checkSides("R3 R6 count 491");
    fill(1);       settle(); checkSides("R3 R6 count 492");
    drain();       settle(); checkSides("R3 after drain");

    // ---- random concurrent traffic with random thresholds (R9) ----
    doReset(2'b00);
    wrA({27'd0, 9'($urandom())}, 4'd0);
    wrIdle();
    wrA({27'd0, 9'($urandom())}, 4'd0);
    wrIdle(); settle();
    checkSides("R3 random thresholds");
    wDone = 1'b0;
    fork
      begin
        for (int i = 0; i < 600; i++) begin
          wrA(rndWord(), ($urandom() % 4 == 0) ? 4'(1 << ($urandom() % 4)) : 4'd0);
          if ($urandom() % 3 == 0) wrIdle();
        end
        wrIdle();
        wDone = 1'b1;
      end
      begin
        int guard = 0;
        while (!(wDone && q.size() == 0) && guard < 20000) begin
          @(negedge clkB);
          if (outputRdy && ($urandom() % 2 == 0)) begin
            chk("R9 concurrent order", rdData, q[0]);
            void'(q.pop_front());
            rdEn = 1'b1;
          end else rdEn = 1'b0;
          guard++;
        end
        @(negedge clkB);
        rdEn = 1'b0;
      end
    join
    settle();
    checkSides("R9 after concurrent run");
    report();
  end

endmodule